// File: doc/BRIEF.md
# Byte Crossbar Shuffle Unit

The unit assembles a 64-bit result from two 64-bit operands. Each of the eight result bytes may be any one of the sixteen bytes in the pair. A 64-bit control word picks the bytes. Its upper half holds eight 4-bit selectors, one for each result byte. Its lower half plays no part.

Both operands form one sixteen-byte pool. Bytes are counted from the most significant byte of the first operand through to the least significant byte of the second operand. A selector is a plain pool number, so several result bytes may name the same source byte. An operation is accepted on any cycle where `valid_in` is high. The result is registered and appears together with `valid_out` one cycle later. While no operation is accepted, the last result is held.

Top module: `bshuf_crossbar`

## Requirements
- R1: Only control bits 63:32 affect the result. Bits 31:0 have no effect.
- R2: Result byte i (i = 0 is bits 63:56, i = 7 is bits 7:0) takes the pool byte whose number is in control bits (63-4i):(60-4i).
- R3: Pool numbers 0..7 name the bytes of `op_hi` from its most significant byte (0 = bits 63:56) down to its least. Numbers 8..15 name the bytes of `op_lo` in the same order (8 = bits 63:56, 15 = bits 7:0).
- R4: Every accepted operation rewrites all eight result bytes. No byte keeps a value from an earlier operation.
- R5: The same selector value may appear in several lanes. Each of those lanes then receives a copy of the same source byte.
- R6: The result of an operation accepted at a clock edge is present on `result` after that edge. `valid_out` is high in exactly the cycle that follows a cycle with `valid_in` high.
- R7: While `valid_in` is low, `result` keeps its value, whatever the operands and the control word do.
- R8: Synchronous active-high reset sets `result` to zero and `valid_out` to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Accept an operation this cycle |
| ctrl_word | input | 64 | Control word; bits 63:32 hold the eight selectors |
| op_hi | input | 64 | First operand (pool bytes 0..7) |
| op_lo | input | 64 | Second operand (pool bytes 8..15) |
| valid_out | output | 1 | Result is fresh this cycle |
| result | output | 64 | Shuffled bytes |

## Verification
The checker assumes that `valid_in`, the operands and the control word are steady and known at each rising edge. It also assumes that reset is held high through the first edge, so that every past value it compares against comes from a cycle after reset. The bench holds reset over several edges. It changes inputs only on falling edges and drives every input to a defined value at all times. For the hold checks, the bench deliberately changes the operands and the control word while `valid_in` is low.

// File: rtl/bshuf_pkg.sv
package bshuf_pkg;
  localparam int DEF_LANES  = 8;
  localparam int DEF_BYTE_W = 8;
  localparam int DEF_CTRL_W = 64;

  function automatic int sel_width(input int pool_bytes);
    return $clog2(pool_bytes);
  endfunction
endpackage

// File: rtl/bshuf_index_unpack.sv
module bshuf_index_unpack #(
  parameter int LANES  = 8,
  parameter int IDX_W  = 4,
  parameter int CTRL_W = 64,
  localparam int MASK_W = LANES * IDX_W
) (
  input  logic [CTRL_W-1:0]      ctrl_i,
  output logic [LANES*IDX_W-1:0] idx_o
);
  logic [MASK_W-1:0] mask;
  logic [CTRL_W-MASK_W-1:0] unused_low;

  assign mask       = ctrl_i[CTRL_W-1 -: MASK_W];
  assign unused_low = ctrl_i[CTRL_W-MASK_W-1:0];

  // lane 0 takes the most significant selector
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign idx_o[g*IDX_W +: IDX_W] = mask[MASK_W-1-g*IDX_W -: IDX_W];
  end
endmodule

// File: rtl/bshuf_lane_mux.sv
module bshuf_lane_mux #(
  parameter int POOL_BYTES = 16,
  parameter int BYTE_W     = 8,
  parameter int IDX_W      = 4,
  localparam int POOL_W    = POOL_BYTES * BYTE_W
) (
  input  logic [POOL_W-1:0] pool_i,
  input  logic [IDX_W-1:0]  sel_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-1:0] cand [POOL_BYTES];

  // pool byte 0 sits in the top bits
  for (genvar k = 0; k < POOL_BYTES; k++) begin : g_cand
    assign cand[k] = pool_i[POOL_W-1-k*BYTE_W -: BYTE_W];
  end

  always_comb begin
    byte_o = '0;
    for (int k = 0; k < POOL_BYTES; k++) begin
      if (int'(sel_i) == k) byte_o = cand[k];
    end
  end
endmodule

// File: rtl/bshuf_out_stage.sv
module bshuf_out_stage #(
  parameter int DATA_W  = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  if (REG_OUT) begin : g_reg
    logic              v_q;
    logic [DATA_W-1:0] d_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else begin
        v_q <= valid_i;
        if (valid_i) d_q <= data_i;
      end
    end
    assign valid_o = v_q;
    assign data_o  = d_q;
  end else begin : g_pass
    logic unused_clk_rst;
    assign unused_clk_rst = clk ^ rst;
    assign valid_o = valid_i;
    assign data_o  = data_i;
  end
endmodule

// File: rtl/bshuf_crossbar.sv
module bshuf_crossbar
  import bshuf_pkg::*;
#(
  parameter int LANES   = DEF_LANES,
  parameter int BYTE_W  = DEF_BYTE_W,
  parameter int CTRL_W  = DEF_CTRL_W,
  parameter bit REG_OUT = 1'b1,
  localparam int DATA_W     = LANES * BYTE_W,
  localparam int POOL_BYTES = 2 * LANES,
  localparam int IDX_W      = sel_width(POOL_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_in,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic [DATA_W-1:0] op_hi,
  input  logic [DATA_W-1:0] op_lo,
  output logic              valid_out,
  output logic [DATA_W-1:0] result
);
  logic [LANES*IDX_W-1:0] idx;
  logic [2*DATA_W-1:0]    pool;
  logic [DATA_W-1:0]      shuffled;

  assign pool = {op_hi, op_lo};

  bshuf_index_unpack #(.LANES(LANES), .IDX_W(IDX_W), .CTRL_W(CTRL_W)) u_unpack (
    .ctrl_i (ctrl_word),
    .idx_o  (idx)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    bshuf_lane_mux #(.POOL_BYTES(POOL_BYTES), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_mux (
      .pool_i (pool),
      .sel_i  (idx[i*IDX_W +: IDX_W]),
      .byte_o (shuffled[DATA_W-1-i*BYTE_W -: BYTE_W])
    );
  end

  bshuf_out_stage #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_out (
    .clk     (clk),
    .rst     (rst),
    .valid_i (valid_in),
    .data_i  (shuffled),
    .valid_o (valid_out),
    .data_o  (result)
  );
endmodule

// File: rtl/bshuf_crossbar_chk.sv
module bshuf_crossbar_chk #(
  parameter int LANES  = 8,
  parameter int BYTE_W = 8,
  parameter int CTRL_W = 64,
  localparam int DATA_W = LANES * BYTE_W,
  localparam int IDX_W  = $clog2(2 * LANES)
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_in,
  input logic [CTRL_W-1:0] ctrl_word,
  input logic [DATA_W-1:0] op_hi,
  input logic [DATA_W-1:0] op_lo,
  input logic              valid_out,
  input logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] want;

  // R2 R3: expected bytes by shifting the pool
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      int unsigned n;
      logic [2*DATA_W-1:0] sh;
      n  = int'(ctrl_word[CTRL_W-1-i*IDX_W -: IDX_W]);
      sh = {op_hi, op_lo} << (n * BYTE_W);
      want[DATA_W-1-i*BYTE_W -: BYTE_W] = sh[2*DATA_W-1 -: BYTE_W];
    end
  end

  assert_select_R2: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> result == $past(want));
  assert_valid_hi_R6: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);
  assert_valid_lo_R6: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out);
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> $stable(result));
  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (!valid_out && result == '0));
endmodule

bind bshuf_crossbar bshuf_crossbar_chk #(.LANES(LANES), .BYTE_W(BYTE_W), .CTRL_W(CTRL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .valid_in  (valid_in),
  .ctrl_word (ctrl_word),
  .op_hi     (op_hi),
  .op_lo     (op_lo),
  .valid_out (valid_out),
  .result    (result)
);

// File: tb/bshuf_crossbar_test.sv
module bshuf_crossbar_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_in = 1'b0;
  logic [63:0] ctrl_word = '0;
  logic [63:0] op_hi = '0;
  logic [63:0] op_lo = '0;
  logic        valid_out;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bshuf_crossbar uut (
    .clk(clk), .rst(rst), .valid_in(valid_in), .ctrl_word(ctrl_word),
    .op_hi(op_hi), .op_lo(op_lo), .valid_out(valid_out), .result(result)
  );

  function automatic logic [63:0] model(input logic [63:0] c, input logic [63:0] a,
                                        input logic [63:0] b);
    logic [7:0] bytes [16];
    logic [63:0] r;
    for (int k = 0; k < 8; k++) begin
      bytes[k]     = a[63-8*k -: 8];
      bytes[k + 8] = b[63-8*k -: 8];
    end
    for (int i = 0; i < 8; i++) r[63-8*i -: 8] = bytes[c[63-4*i -: 4]];
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [63:0] c, input logic [63:0] a,
                        input logic [63:0] b);
    @(negedge clk);
    ctrl_word = c; op_hi = a; op_lo = b; valid_in = 1'b1;
    @(negedge clk);
    valid_in = 1'b0;
    check(req, result, model(c, a, b));
    check({req, " R6 valid"}, {63'd0, valid_out}, 64'd1);
  endtask

  localparam logic [63:0] A = 64'h0011223344556677;
  localparam logic [63:0] B = 64'h8899AABBCCDDEEFF;

  initial begin
    logic [63:0] prev;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    check("R8 result", result, 64'd0);
    check("R8 valid", {63'd0, valid_out}, 64'd0);
    rst = 1'b0;

    run_op("R3 first operand", 64'h01234567_00000000, A, B);
    check("R3 direct", result, A);
    run_op("R3 second operand", 64'h89ABCDEF_00000000, A, B);
    check("R3 direct2", result, B);
    run_op("R2 reversed", 64'hFEDCBA98_00000000, A, B);
    check("R2 direct", result, 64'hFFEEDDCCBBAA9988);
    run_op("R5 broadcast", 64'h77777777_00000000, A, B);
    check("R5 direct", result, {8{8'h77}});
    run_op("R1 low ctrl ignored", 64'h0F1E2D3C_FFFFFFFF, A, B);
    check("R1 direct", result, 64'h00FF11EE22DD33CC);
    run_op("R4 full rewrite", 64'h8888CCCC_12345678, 64'h0, 64'h5A00000000000000);
    check("R4 direct", result, 64'h5A5A5A5A00000000);

    // R7: inputs change while valid_in low
    prev = result;
    @(negedge clk);
    ctrl_word = 64'hFFFFFFFF_FFFFFFFF; op_hi = ~A; op_lo = ~B;
    @(negedge clk);
    check("R7 hold", result, prev);
    check("R6 idle valid", {63'd0, valid_out}, 64'd0);

    for (int n = 0; n < 300; n++) begin
      run_op("R2 random", {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
    end

    // R6 back-to-back operations
    @(negedge clk);
    ctrl_word = 64'h01234567_00000000; op_hi = A; op_lo = B; valid_in = 1'b1;
    @(negedge clk);
    check("R6 b2b first", result, A);
    ctrl_word = 64'h89ABCDEF_00000000;
    @(negedge clk);
    valid_in = 1'b0;
    check("R6 b2b second", result, B);
    check("R6 b2b valid", {63'd0, valid_out}, 64'd1);
    @(negedge clk);
    check("R6 drop valid", {63'd0, valid_out}, 64'd0);

    // R8 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    check("R8 reset again", result, 64'd0);
    rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule